// File: doc/BRIEF.md
# UART Receive Status Request Unit

This block holds the receive-side status word of a high-speed UART and converts status events into an interrupt line and a DMA request line. Each received byte arrives as a one-cycle strobe. The strobe carries the byte, a frame-good indication and the level of the carrier-detect input at the moment the frame is checked. The block compares the byte with a configured control character. In non-FIFO mode it keeps the byte in a single holding buffer. In FIFO mode the block does not hold the FIFO storage. It sees the FIFO only through occupancy and trigger-level inputs.

Software reads the status word at any time. A register-bus write clears selected sticky flags when it writes a 1 to their bit positions. A read strobe tells the block that the current byte has been taken. A 2-bit request-mode field sends the data-ready flag to the interrupt line, to the DMA request line, or to neither. The error flags always reach the interrupt line through their own enable bits.

Top module: `uart_rx_status_unit`

## Requirements
- R1: While reset is held, and in the first cycle after it, the status word is 0x100 with only the FIFO-empty flag set. The interrupt and DMA request outputs are 0.
- R2: In non-FIFO mode, a byte strobe that arrives while the holding buffer holds an unread byte sets bit 4 (overrun). The new byte is dropped and the held byte stays on `hold_data`.
- R3: In FIFO mode, a byte strobe that arrives while the occupancy equals DEPTH sets both bit 4 and bit 10 (FIFO overrun).
- R4: Bits 4, 5, 6 and 10 are sticky. Writing 1 at a bit's position clears that bit. Writing 0 leaves it unchanged. If a set event and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R5: Bit 5 sets when a strobed byte equals `ctrl_char`. The byte is still taken normally.
- R6: Bit 6 sets when `dcd_in` is high during a byte strobe.
- R7: Bit 7 (data ready) is set in FIFO mode when the occupancy is non-zero and at or above `fifo_trig`. In non-FIFO mode it is set while the holding buffer holds a byte.
- R8: A read strobe releases a good held byte and clears bit 7. A held byte is errored if it came with `rx_frame_ok` low or `dcd_in` high. A read strobe does not release an errored byte; only writing 1 to bit 6 releases it.
- R9: Bit 8 shows an occupancy of zero, bit 9 shows an occupancy of DEPTH, and bit 11 shows an idle receive line. These bits are read-only monitors that writes cannot change. Bits 3..0 read 0.
- R10: `irq` is a register that is set one cycle after the status word holds a set bit 4, 5 or 6 whose `int_en` bit at the same position is 1. It is also set one cycle after bit 7 is set while the request mode is 01 and `int_en[7]` is 1.
- R11: `dma_req` is a register that is set one cycle after bit 7 is set while the request mode is 10 or 11. Request mode 00 drives neither `dma_req` nor the data-ready part of `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_strobe | input | 1 | One-cycle strobe for a received byte |
| rx_byte | input | 8 | Received byte |
| rx_frame_ok | input | 1 | Frame passed its validity check |
| dcd_in | input | 1 | Carrier-detect input sampled at the frame check |
| rx_line_idle | input | 1 | Receive data line is inactive |
| ctrl_char | input | 8 | Configured control character |
| fifo_mode | input | 1 | 1 = FIFO buffering, 0 = single holding buffer |
| fifo_level | input | $clog2(DEPTH+1) | Receive FIFO occupancy |
| fifo_trig | input | $clog2(DEPTH+1) | Receive trigger level |
| req_mode | input | 2 | 00 none, 01 interrupt, 10/11 DMA for data ready |
| int_en | input | 12 | Interrupt enables at status bit positions |
| rd_strobe | input | 1 | Current byte has been read |
| wr_en | input | 1 | Status write strobe |
| wr_data | input | 12 | Write-one-to-clear mask |
| status | output | 12 | Status word |
| hold_data | output | 8 | Holding buffer contents |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |

## Verification
The assertions check the per-cycle rules on every clock. These rules are the sticky-flag ordering (a set wins, a clear takes effect in the next cycle, and a flag holds when neither happens), holding-buffer retention during overrun, the FIFO-overrun double flag, the empty/full exclusion, and the one-cycle lag of the request lines. The bench scenarios cover the behaviours that take several steps. These are a good read compared with an errored read that needs a bit-6 write to release the byte, mode switching between buffering schemes, the dropped overrun byte seen on `hold_data`, and the write-protection of the monitor bits.

// File: rtl/urs_pkg.sv
// Shared definitions for the receive status unit: status bit positions that
// software decodes and the request-mode encoding. Assumes a 12-bit status word.
package urs_pkg;
    localparam int STAT_W  = 12;
    localparam int B_OVR   = 4;
    localparam int B_CCD   = 5;
    localparam int B_DCD   = 6;
    localparam int B_RDY   = 7;
    localparam int B_EMPTY = 8;
    localparam int B_FULL  = 9;
    localparam int B_FOVR  = 10;
    localparam int B_IDLE  = 11;

    typedef enum logic [1:0] {
        REQ_OFF  = 2'b00,
        REQ_IRQ  = 2'b01,
        REQ_DMA  = 2'b10,
        REQ_DMA2 = 2'b11
    } req_mode_e;
endpackage

// File: rtl/urs_flag_bank.sv
// Bank of sticky event flags. Each flag sets on its event and clears on a
// write-one request. A set in the same cycle as a clear wins.
// Assumes set_i and clr_i are single-cycle pulses that clk samples.
module urs_flag_bank #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_o
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        // One sticky flag: set has priority over clear.
        always_ff @(posedge clk) begin
            if (!rst_n)          flag_o[i] <= 1'b0;
            else if (set_i[i])   flag_o[i] <= 1'b1;
            else if (clr_i[i])   flag_o[i] <= 1'b0;
        end

        a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> flag_o[i]);
        a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[i] && !set_i[i]) |=> !flag_o[i]);
        a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr_i[i] && !set_i[i]) |=> $stable(flag_o[i]));
    end
endmodule

// File: rtl/urs_hold_buf.sv
// Single-byte holding buffer for non-FIFO mode. It captures a byte only when
// empty, so an arrival while full is reported as overrun and dropped. A read
// releases a good byte. An errored byte is released only by release_i.
module urs_hold_buf #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [DW-1:0] data_i,
    input  logic          err_i,
    input  logic          rd_i,
    input  logic          release_i,
    output logic          valid_o,
    output logic          err_o,
    output logic [DW-1:0] data_o,
    output logic          overrun_o
);
    // Overrun: a byte arrives while the previous byte is still held.
    assign overrun_o = load_i && valid_o;

    // Buffer state: capture when empty, otherwise process a release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            err_o   <= 1'b0;
            data_o  <= '0;
        end else if (load_i && !valid_o) begin
            valid_o <= 1'b1;
            err_o   <= err_i;
            data_o  <= data_i;
        end else if (valid_o && !err_o && rd_i) begin
            valid_o <= 1'b0;
        end else if (valid_o && err_o && release_i) begin
            valid_o <= 1'b0;
            err_o   <= 1'b0;
        end
    end

    a_r2_keep_held: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && load_i && !rd_i && !release_i) |=> (valid_o && $stable(data_o)));
    a_r8_err_needs_release: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && err_o && !release_i) |=> valid_o);
endmodule

// File: rtl/urs_req_gen.sv
// Request generator: forms the registered interrupt and DMA request lines
// from the current status word, the enable word and the request mode.
// Both outputs lag the status word by one cycle.
module urs_req_gen
    import urs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] status_i,
    input  logic [STAT_W-1:0] int_en_i,
    input  logic [1:0]        req_mode_i,
    output logic              irq_o,
    output logic              dma_o
);
    req_mode_e mode;
    logic      err_hit;
    logic      rdy_irq;
    logic      rdy_dma;

    // Decode the mode and the enabled sources.
    always_comb begin
        mode    = req_mode_e'(req_mode_i);
        err_hit = |(status_i[B_DCD:B_OVR] & int_en_i[B_DCD:B_OVR]);
        rdy_irq = status_i[B_RDY] && (mode == REQ_IRQ) && int_en_i[B_RDY];
        rdy_dma = status_i[B_RDY] && (mode == REQ_DMA || mode == REQ_DMA2);
    end

    // Register both request lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o <= 1'b0;
            dma_o <= 1'b0;
        end else begin
            irq_o <= err_hit || rdy_irq;
            dma_o <= rdy_dma;
        end
    end

    a_r11_off_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (req_mode_i == 2'b00) |=> !dma_o);
    a_r11_dma_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (status_i[B_RDY] && req_mode_i[1]) |=> dma_o);
    a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!status_i[B_RDY] && (status_i[B_DCD:B_OVR] & int_en_i[B_DCD:B_OVR]) == 3'b000) |=> !irq_o);
endmodule

// File: rtl/uart_rx_status_unit.sv
// Receive status unit top. It assembles the status word from the sticky error
// flags, the holding buffer and the registered FIFO monitors, and drives the
// request lines. Assumes that fifo_level never exceeds DEPTH and that
// rx_strobe lasts one cycle per byte.
module uart_rx_status_unit
    import urs_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int DW    = 8,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_strobe,
    input  logic [DW-1:0]     rx_byte,
    input  logic              rx_frame_ok,
    input  logic              dcd_in,
    input  logic              rx_line_idle,
    input  logic [DW-1:0]     ctrl_char,
    input  logic              fifo_mode,
    input  logic [LVL_W-1:0]  fifo_level,
    input  logic [LVL_W-1:0]  fifo_trig,
    input  logic [1:0]        req_mode,
    input  logic [STAT_W-1:0] int_en,
    input  logic              rd_strobe,
    input  logic              wr_en,
    input  logic [STAT_W-1:0] wr_data,
    output logic [STAT_W-1:0] status,
    output logic [DW-1:0]     hold_data,
    output logic              irq,
    output logic              dma_req
);
    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

    logic       full_now;
    logic       hb_load;
    logic       hb_valid;
    logic       hb_err;
    logic       hb_ovr;
    logic [3:0] ev_set;
    logic [3:0] ev_clr;
    logic [3:0] ev_flag;
    logic       mode_q, rdy_fifo_q, empty_q, full_q, idle_q;

    // Decode the events produced by the current strobe and write.
    always_comb begin
        full_now = (fifo_level == FULL_LVL);
        hb_load  = rx_strobe && !fifo_mode;
        ev_set[0] = fifo_mode ? (rx_strobe && full_now) : hb_ovr;
        ev_set[1] = rx_strobe && (rx_byte == ctrl_char);
        ev_set[2] = rx_strobe && dcd_in;
        ev_set[3] = rx_strobe && fifo_mode && full_now;
        ev_clr    = {wr_data[B_FOVR], wr_data[B_DCD], wr_data[B_CCD], wr_data[B_OVR]}
                    & {4{wr_en}};
    end

    urs_flag_bank #(.N(4)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (ev_set),
        .clr_i  (ev_clr),
        .flag_o (ev_flag)
    );

    urs_hold_buf #(.DW(DW)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (hb_load),
        .data_i    (rx_byte),
        .err_i     (!rx_frame_ok || dcd_in),
        .rd_i      (rd_strobe),
        .release_i (wr_en && wr_data[B_DCD]),
        .valid_o   (hb_valid),
        .err_o     (hb_err),
        .data_o    (hold_data),
        .overrun_o (hb_ovr)
    );

    // Register the occupancy monitors and the buffering mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q     <= 1'b0;
            rdy_fifo_q <= 1'b0;
            empty_q    <= 1'b1;
            full_q     <= 1'b0;
            idle_q     <= 1'b0;
        end else begin
            mode_q     <= fifo_mode;
            rdy_fifo_q <= (fifo_level != '0) && (fifo_level >= fifo_trig);
            empty_q    <= (fifo_level == '0);
            full_q     <= full_now;
            idle_q     <= rx_line_idle;
        end
    end

    // Assemble the status word.
    always_comb begin
        status          = '0;
        status[B_OVR]   = ev_flag[0];
        status[B_CCD]   = ev_flag[1];
        status[B_DCD]   = ev_flag[2];
        status[B_RDY]   = mode_q ? rdy_fifo_q : hb_valid;
        status[B_EMPTY] = empty_q;
        status[B_FULL]  = full_q;
        status[B_FOVR]  = ev_flag[3];
        status[B_IDLE]  = idle_q;
    end

    urs_req_gen u_req (
        .clk        (clk),
        .rst_n      (rst_n),
        .status_i   (status),
        .int_en_i   (int_en),
        .req_mode_i (req_mode),
        .irq_o      (irq),
        .dma_o      (dma_req)
    );

    a_r9_empty_full_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(status[B_EMPTY] && status[B_FULL]));
    a_r3_fifo_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_strobe && fifo_mode && full_now) |=> (status[B_OVR] && status[B_FOVR]));
    a_r6_carrier: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_strobe && dcd_in) |=> status[B_DCD]);
    a_r8_errored_not_read: assert property (@(posedge clk) disable iff (!rst_n)
        (hb_valid && hb_err && !wr_en) |=> hb_valid);
endmodule

// File: tb/uart_rx_status_unit_tb.sv
module uart_rx_status_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        rx_strobe, rx_frame_ok, dcd_in, rx_line_idle;
    logic [7:0]  rx_byte, ctrl_char;
    logic        fifo_mode;
    logic [3:0]  fifo_level, fifo_trig;
    logic [1:0]  req_mode;
    logic [11:0] int_en;
    logic        rd_strobe, wr_en;
    logic [11:0] wr_data;
    logic [11:0] status;
    logic [7:0]  hold_data;
    logic        irq, dma_req;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    uart_rx_status_unit #(.DEPTH(8), .DW(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .rx_strobe(rx_strobe), .rx_byte(rx_byte),
        .rx_frame_ok(rx_frame_ok), .dcd_in(dcd_in), .rx_line_idle(rx_line_idle),
        .ctrl_char(ctrl_char), .fifo_mode(fifo_mode), .fifo_level(fifo_level),
        .fifo_trig(fifo_trig), .req_mode(req_mode), .int_en(int_en),
        .rd_strobe(rd_strobe), .wr_en(wr_en), .wr_data(wr_data),
        .status(status), .hold_data(hold_data), .irq(irq), .dma_req(dma_req)
    );

    typedef struct packed {
        logic        fm;
        logic [3:0]  lvl;
        logic [3:0]  trg;
        logic        rx;
        logic [7:0]  dat;
        logic        ok;
        logic        dcd;
        logic        rd;
        logic        wr;
        logic [11:0] wd;
        logic [1:0]  md;
        logic [11:0] en;
        logic [11:0] st;
        logic        xirq;
        logic        xdma;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t VECS [NV] = '{
        '{1'b0,4'd0,4'd1,1'b0,8'h00,1'b1,1'b0,1'b0,1'b0,12'h000,2'b01,12'h000,12'h900,1'b0,1'b0},
        '{1'b0,4'd0,4'd1,1'b1,8'h41,1'b1,1'b0,1'b0,1'b0,12'h000,2'b01,12'h080,12'h980,1'b1,1'b0},
        '{1'b0,4'd0,4'd1,1'b0,8'h00,1'b1,1'b0,1'b1,1'b0,12'h000,2'b01,12'h080,12'h900,1'b0,1'b0},
        '{1'b0,4'd0,4'd1,1'b1,8'h13,1'b1,1'b0,1'b0,1'b0,12'h000,2'b01,12'h020,12'h9A0,1'b1,1'b0},
        '{1'b0,4'd0,4'd1,1'b1,8'h55,1'b1,1'b0,1'b0,1'b0,12'h000,2'b01,12'h020,12'h9B0,1'b1,1'b0},
        '{1'b0,4'd0,4'd1,1'b0,8'h00,1'b1,1'b0,1'b0,1'b1,12'h030,2'b01,12'h030,12'h980,1'b0,1'b0},
        '{1'b0,4'd0,4'd1,1'b0,8'h00,1'b1,1'b0,1'b0,1'b0,12'h000,2'b10,12'h000,12'h980,1'b0,1'b1},
        '{1'b0,4'd0,4'd1,1'b0,8'h00,1'b1,1'b0,1'b1,1'b0,12'h000,2'b10,12'h000,12'h900,1'b0,1'b0},
        '{1'b0,4'd0,4'd1,1'b1,8'h22,1'b1,1'b1,1'b0,1'b0,12'h000,2'b10,12'h040,12'h9C0,1'b1,1'b1},
        '{1'b0,4'd0,4'd1,1'b0,8'h00,1'b1,1'b0,1'b1,1'b0,12'h000,2'b00,12'h000,12'h9C0,1'b0,1'b0},
        '{1'b0,4'd0,4'd1,1'b0,8'h00,1'b1,1'b0,1'b0,1'b1,12'h040,2'b00,12'h000,12'h900,1'b0,1'b0},
        '{1'b0,4'd0,4'd1,1'b1,8'h77,1'b0,1'b0,1'b0,1'b0,12'h000,2'b11,12'h000,12'h980,1'b0,1'b1},
        '{1'b0,4'd0,4'd1,1'b0,8'h00,1'b1,1'b0,1'b1,1'b0,12'h000,2'b11,12'h000,12'h980,1'b0,1'b1},
        '{1'b0,4'd0,4'd1,1'b0,8'h00,1'b1,1'b0,1'b0,1'b1,12'h040,2'b11,12'h000,12'h900,1'b0,1'b0},
        '{1'b1,4'd0,4'd2,1'b0,8'h00,1'b1,1'b0,1'b0,1'b0,12'h000,2'b10,12'h000,12'h900,1'b0,1'b0},
        '{1'b1,4'd1,4'd2,1'b0,8'h00,1'b1,1'b0,1'b0,1'b0,12'h000,2'b10,12'h000,12'h800,1'b0,1'b0},
        '{1'b1,4'd2,4'd2,1'b0,8'h00,1'b1,1'b0,1'b0,1'b0,12'h000,2'b10,12'h000,12'h880,1'b0,1'b1},
        '{1'b1,4'd8,4'd2,1'b0,8'h00,1'b1,1'b0,1'b0,1'b0,12'h000,2'b10,12'h000,12'hA80,1'b0,1'b1},
        '{1'b1,4'd8,4'd2,1'b1,8'h13,1'b1,1'b0,1'b0,1'b0,12'h000,2'b01,12'h000,12'hEB0,1'b0,1'b0},
        '{1'b1,4'd8,4'd2,1'b0,8'h00,1'b1,1'b0,1'b0,1'b1,12'h400,2'b01,12'h010,12'hAB0,1'b1,1'b0},
        '{1'b1,4'd8,4'd2,1'b0,8'h00,1'b1,1'b0,1'b0,1'b1,12'h000,2'b01,12'h000,12'hAB0,1'b0,1'b0},
        '{1'b1,4'd3,4'd2,1'b0,8'h00,1'b1,1'b0,1'b0,1'b1,12'h030,2'b00,12'h080,12'h880,1'b0,1'b0},
        '{1'b1,4'd3,4'd2,1'b0,8'h00,1'b1,1'b0,1'b0,1'b0,12'h000,2'b01,12'h080,12'h880,1'b1,1'b0},
        '{1'b1,4'd3,4'd2,1'b1,8'h13,1'b1,1'b0,1'b0,1'b1,12'h020,2'b00,12'h000,12'h8A0,1'b0,1'b0},
        '{1'b1,4'd3,4'd2,1'b0,8'h00,1'b1,1'b0,1'b0,1'b1,12'h020,2'b00,12'h000,12'h880,1'b0,1'b0}
    };

    function automatic string vreq(int i);
        case (i)
            0:  return "R9 R7";
            1:  return "R7 R10";
            2:  return "R8";
            3:  return "R5";
            4:  return "R2";
            5:  return "R4";
            6:  return "R11";
            7:  return "R8";
            8:  return "R6 R8";
            9:  return "R8 R11";
            10: return "R8 R4";
            11: return "R8 R11";
            12: return "R8";
            13: return "R8";
            14: return "R9";
            15: return "R9 R7";
            16: return "R7 R11";
            17: return "R9";
            18: return "R3 R5";
            19: return "R4 R10";
            20: return "R4";
            21: return "R11 R10";
            22: return "R10";
            23: return "R4";
            default: return "R4";
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic idle_pulses();
        rx_strobe = 1'b0; rd_strobe = 1'b0; wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic run_vec(input vec_t v, input string req);
        @(negedge clk);
        fifo_mode = v.fm; fifo_level = v.lvl; fifo_trig = v.trg;
        rx_strobe = v.rx; rx_byte = v.dat; rx_frame_ok = v.ok; dcd_in = v.dcd;
        rd_strobe = v.rd; wr_en = v.wr; wr_data = v.wd;
        req_mode = v.md; int_en = v.en;
        @(negedge clk);
        idle_pulses();
        @(negedge clk);
        chk({req, " status"}, 32'(status), 32'(v.st));
        chk({req, " irq"}, 32'(irq), 32'(v.xirq));
        chk({req, " dma"}, 32'(dma_req), 32'(v.xdma));
    endtask

    initial begin
        #(200000 * 4);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        idle_pulses();
        rx_byte = '0; rx_frame_ok = 1'b1; dcd_in = 1'b0; rx_line_idle = 1'b1;
        ctrl_char = 8'h13; fifo_mode = 1'b0; fifo_level = '0; fifo_trig = 4'd1;
        req_mode = 2'b01; int_en = 12'hFFF;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 status", 32'(status), 32'h100);
        chk("R1 irq", 32'(irq), 32'h0);
        chk("R1 dma", 32'(dma_req), 32'h0);
        int_en = '0;
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) run_vec(VECS[i], vreq(i));

        // R9: line not idle, and a write of all ones leaves monitor bits intact
        @(negedge clk); rx_line_idle = 1'b0;
        @(negedge clk); wr_en = 1'b1; wr_data = 12'hFFF;
        @(negedge clk); idle_pulses();
        @(negedge clk);
        chk("R9 monitors", 32'(status), 32'h080);

        // R2: dropped byte in non-FIFO mode, held byte stays visible
        fifo_mode = 1'b0; fifo_level = '0; req_mode = 2'b01; int_en = 12'h010;
        @(negedge clk); rx_strobe = 1'b1; rx_byte = 8'h41;
        @(negedge clk); rx_byte = 8'h55;
        @(negedge clk); idle_pulses();
        // R10: status shows overrun now, irq only one cycle later
        chk("R2 overrun", 32'(status), 32'h190);
        chk("R10 lag", 32'(irq), 32'h0);
        chk("R2 held byte", 32'(hold_data), 32'h41);
        @(negedge clk);
        chk("R10 irq", 32'(irq), 32'h1);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule